// File: doc/BRIEF.md
# Measurement Scheduler with Rate Control

This block decides when a three-axis sensing front end runs its conversions. A 1280 Hz tick enable drives a divider whose setting comes from a 3-bit rate code. The divided tick paces the ADC conversions. The block counts a number of conversions set by a 2-bit oversampling code, and that count forms one output-sample window. Each window opens with a one-cycle start strobe to the conversion path and closes with a one-cycle sample-complete strobe.

The operating mode comes from an 8-bit control byte held in the block. When the active bit is set, windows follow one another without a gap. When it is clear, the block stays in standby, but a trigger bit can request one measurement, and that bit clears itself when the measurement finishes. A one-shot sensor reset request produces a busy flag that holds for a fixed number of base ticks. An enable input can also insert the same reset interval in front of every window. The block reports a 2-bit system mode in the low bits of a status byte.

Top module: `meas_sched`

## Requirements
- R1: After a synchronous reset, the control byte reads 0x00, the status byte reads 0x00, and the busy flag, start strobe and sample-complete strobe are all low.
- R2: The control byte holds the active bit at bit 0, the trigger bit at bit 1, the fast-read bit at bit 2, the oversampling code at bits 4:3 and the rate code at bits 7:5. A write is read back unchanged, except in the case covered by R8.
- R3: With continuous base ticks, a window lasts (2^min(rate,4)) x (16 x 2^os) base ticks. The sample-complete strobe rises that many cycles after the start strobe. Each strobe is one cycle wide.
- R4: Rate codes 5, 6 and 7 give the same window length as rate code 4.
- R5: While the active bit is set, the next start strobe follows the sample-complete strobe by exactly one cycle.
- R6: With both the active bit and the trigger bit clear, no start strobe is issued, whatever the other fields hold.
- R7: Setting the trigger bit in standby runs exactly one window. The trigger bit reads 0 from the cycle the sample-complete strobe is seen, and no further start follows.
- R8: A write that sets both the active bit and the trigger bit stores the trigger bit as 0.
- R9: A change of rate or oversampling code during a window leaves that window's length unchanged and applies from the next window.
- R10: The status byte reads 0 in standby, 1 when active with raw output selected (raw input high) and 2 when active with corrected output (raw input low). Bits 7:2 always read 0. The status byte follows the control byte and the raw input with one register delay.
- R11: A reset request pulse raises the busy flag on the next cycle. The flag holds for exactly RST_TICKS base ticks and then clears itself.
- R12: With automatic reset enabled, each window is preceded by a busy interval of RST_TICKS base ticks. The start strobe rises in the same cycle the busy flag falls.
- R13: While the tick enable is low, neither the window count nor the reset interval advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 1280 Hz base tick enable, one cycle per tick |
| ctl_wr_i | input | 1 | Write strobe for the control byte |
| ctl_wdata_i | input | 8 | Control byte write data |
| raw_i | input | 1 | High selects raw output, low selects offset-corrected output |
| auto_rst_en_i | input | 1 | Inserts a reset interval before every window |
| rst_req_i | input | 1 | One-cycle sensor reset request |
| ctl_q_o | output | 8 | Control byte readback |
| sysmode_o | output | 8 | Status byte carrying the system mode in bits 1:0 |
| rst_busy_o | output | 1 | Sensor reset cycle in progress |
| conv_start_o | output | 1 | One-cycle strobe at the start of a window |
| sample_done_o | output | 1 | One-cycle strobe at the end of a window |

## Verification
The bench keeps the default rate saturation code of 4 and the default minimum oversampling exponent of 4. With these values, rate codes above 4 reach the clamp, and windows of 16 to 512 ticks can be measured cycle by cycle with the tick held high. The bench lowers RST_TICKS to 5, which keeps the reset interval short enough to count exactly, both on its own and in front of each window. Pausing the tick in the middle of a window and in the middle of a reset shows that both counts hold their place.

// File: rtl/meas_sched_pkg.sv
package meas_sched_pkg;

  // Control byte bit positions (software decodes these).
  localparam int CTL_ACT_BIT  = 0;
  localparam int CTL_TRIG_BIT = 1;
  localparam int CTL_FAST_BIT = 2;
  localparam int CTL_OS_LSB   = 3;
  localparam int CTL_OS_W     = 2;
  localparam int CTL_RATE_LSB = 5;
  localparam int CTL_RATE_W   = 3;
  localparam int CTL_W        = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RST  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_ACT_RAW = 2'd1,
    MODE_ACT_COR = 2'd2
  } sys_mode_e;

endpackage

// File: rtl/meas_sched_ctl.sv
module meas_sched_ctl
  import meas_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             trig_clr_i,
  input  logic             raw_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output logic [CTL_W-1:0] sysmode_o
);

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] mode_q;
  sys_mode_e        mode_n;

  // A trigger written together with the active bit is dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_i) begin
      ctl_q               <= wdata_i;
      ctl_q[CTL_TRIG_BIT] <= wdata_i[CTL_TRIG_BIT] & ~wdata_i[CTL_ACT_BIT];
    end else if (trig_clr_i) begin
      ctl_q[CTL_TRIG_BIT] <= 1'b0;
    end
  end

  always_comb begin
    if (!ctl_q[CTL_ACT_BIT]) mode_n = MODE_STANDBY;
    else if (raw_i)          mode_n = MODE_ACT_RAW;
    else                     mode_n = MODE_ACT_COR;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= {{(CTL_W-2){1'b0}}, mode_n};
  end

  assign ctl_q_o   = ctl_q;
  assign sysmode_o = mode_q;

  // R8: stored trigger never coexists with the active bit
  p_trig_masked_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_ACT_BIT] |-> !ctl_q[CTL_TRIG_BIT]);

  // R7: completion of a single measurement drops the trigger
  p_trig_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (trig_clr_i && !wr_i) |=> !ctl_q[CTL_TRIG_BIT]);

  // R10: standby always reports mode zero one cycle later
  p_standby_mode_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[CTL_ACT_BIT] |=> (sysmode_o == '0));

endmodule

// File: rtl/meas_sched_rst_timer.sv
module meas_sched_rst_timer #(
  parameter int RST_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && tick_i && (cnt_q == LAST) && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  // R13: without a tick the reset interval cannot end
  p_busy_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick_i && !start_i) |=> busy_q);

  // R11: a request always produces a busy cycle
  p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_q);

endmodule

// File: rtl/meas_sched_seq.sv
module meas_sched_seq
  import meas_sched_pkg::*;
#(
  parameter int RATE_SAT     = 4,
  parameter int OSR_MIN_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic                  active_i,
  input  logic                  trig_i,
  input  logic [CTL_RATE_W-1:0] rate_i,
  input  logic [CTL_OS_W-1:0]   os_i,
  input  logic                  auto_en_i,
  input  logic                  rst_done_i,
  output logic                  auto_go_o,
  output logic                  trig_clr_o,
  output logic                  conv_start_o,
  output logic                  sample_done_o
);

  localparam int SUB_W = (RATE_SAT > 0) ? RATE_SAT : 1;
  localparam int CNT_W = OSR_MIN_LOG2 + (1 << CTL_OS_W) - 1;

  seq_state_e            state_q;
  logic [SUB_W-1:0]      sub_q, sub_last_q, sub_last_n;
  logic [CNT_W-1:0]      cnt_q, cnt_last_q, cnt_last_n;
  logic                  shot_q;
  logic                  start_req;
  logic                  win_end;
  logic [CTL_RATE_W-1:0] rate_eff;
  logic                  start_q, done_q;

  assign start_req = active_i | trig_i;
  assign rate_eff  = (int'(rate_i) > RATE_SAT) ? CTL_RATE_W'(RATE_SAT) : rate_i;

  // Terminal counts as low-bit masks: divider 2^rate_eff, ratio 2^(min+os).
  always_comb begin
    for (int i = 0; i < SUB_W; i++)
      sub_last_n[i] = (i < int'(rate_eff));
    for (int j = 0; j < CNT_W; j++)
      cnt_last_n[j] = (j < OSR_MIN_LOG2 + int'(os_i));
  end

  assign win_end    = (state_q == SEQ_RUN) && tick_i &&
                      (sub_q == sub_last_q) && (cnt_q == cnt_last_q);
  assign trig_clr_o = win_end && shot_q;
  assign auto_go_o  = (state_q == SEQ_IDLE) && start_req && auto_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      sub_q      <= '0;
      cnt_q      <= '0;
      sub_last_q <= '0;
      cnt_last_q <= '0;
      shot_q     <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start_req) begin
            sub_last_q <= sub_last_n;
            cnt_last_q <= cnt_last_n;
            sub_q      <= '0;
            cnt_q      <= '0;
            shot_q     <= ~active_i;
            if (auto_en_i) begin
              state_q <= SEQ_RST;
            end else begin
              state_q <= SEQ_RUN;
              start_q <= 1'b1;
            end
          end
        end
        SEQ_RST: begin
          if (rst_done_i) begin
            state_q <= SEQ_RUN;
            start_q <= 1'b1;
          end
        end
        SEQ_RUN: begin
          if (tick_i) begin
            if (sub_q == sub_last_q) begin
              sub_q <= '0;
              if (cnt_q == cnt_last_q) begin
                done_q  <= 1'b1;
                state_q <= SEQ_IDLE;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start_o  = start_q;
  assign sample_done_o = done_q;

  // R3: strobes are single-cycle
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R13: window progress freezes while the tick is low
  p_no_tick_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && !tick_i) |=> ($stable(sub_q) && $stable(cnt_q)));

  // R9: terminal counts stay fixed for the whole window
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && $past(state_q) == SEQ_RUN) |->
      ($stable(sub_last_q) && $stable(cnt_last_q)));

endmodule

// File: rtl/meas_sched.sv
module meas_sched
  import meas_sched_pkg::*;
#(
  parameter int RATE_SAT     = 4,
  parameter int OSR_MIN_LOG2 = 4,
  parameter int RST_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       raw_i,
  input  logic       auto_rst_en_i,
  input  logic       rst_req_i,
  output logic [7:0] ctl_q_o,
  output logic [7:0] sysmode_o,
  output logic       rst_busy_o,
  output logic       conv_start_o,
  output logic       sample_done_o
);

  logic [CTL_W-1:0] ctl_q;
  logic             trig_clr;
  logic             auto_go;
  logic             rst_done;

  meas_sched_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (ctl_wr_i),
    .wdata_i    (ctl_wdata_i),
    .trig_clr_i (trig_clr),
    .raw_i      (raw_i),
    .ctl_q_o    (ctl_q),
    .sysmode_o  (sysmode_o)
  );

  meas_sched_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst_timer (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .start_i (rst_req_i | auto_go),
    .busy_o  (rst_busy_o),
    .done_o  (rst_done)
  );

  meas_sched_seq #(
    .RATE_SAT     (RATE_SAT),
    .OSR_MIN_LOG2 (OSR_MIN_LOG2)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .active_i      (ctl_q[CTL_ACT_BIT]),
    .trig_i        (ctl_q[CTL_TRIG_BIT]),
    .rate_i        (ctl_q[CTL_RATE_LSB +: CTL_RATE_W]),
    .os_i          (ctl_q[CTL_OS_LSB +: CTL_OS_W]),
    .auto_en_i     (auto_rst_en_i),
    .rst_done_i    (rst_done),
    .auto_go_o     (auto_go),
    .trig_clr_o    (trig_clr),
    .conv_start_o  (conv_start_o),
    .sample_done_o (sample_done_o)
  );

  assign ctl_q_o = ctl_q;

  // R12: with automatic reset, a window never starts while busy remains set
  p_auto_start_r12: assert property (@(posedge clk) disable iff (rst)
    (conv_start_o && auto_rst_en_i && $past(auto_rst_en_i)) |-> !rst_busy_o);

endmodule

// File: tb/meas_sched_tb.sv
module meas_sched_tb;

  localparam int RST_T = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b1;
  logic       ctl_wr_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       raw_i = 1'b0;
  logic       auto_rst_en_i = 1'b0;
  logic       rst_req_i = 1'b0;
  logic [7:0] ctl_q_o, sysmode_o;
  logic       rst_busy_o, conv_start_o, sample_done_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  meas_sched #(.RST_TICKS(RST_T)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ctl_wr_i(ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i), .raw_i(raw_i), .auto_rst_en_i(auto_rst_en_i),
    .rst_req_i(rst_req_i), .ctl_q_o(ctl_q_o), .sysmode_o(sysmode_o),
    .rst_busy_o(rst_busy_o), .conv_start_o(conv_start_o),
    .sample_done_o(sample_done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_wr_i = 1'b1; ctl_wdata_i = d;
    @(negedge clk); ctl_wr_i = 1'b0;
  endtask

  task automatic wait_start(output int seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (conv_start_o) begin seen = 1; break; end
    end
  endtask

  task automatic measure(output int len, input int mid_at, input logic [7:0] mid_d);
    len = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ctl_wr_i = 1'b0;
      len++;
      if (sample_done_o) break;
      if (mid_at > 0 && len == mid_at) begin ctl_wr_i = 1'b1; ctl_wdata_i = mid_d; end
    end
  endtask

  task automatic stop_all();
    wr_ctl(8'h00);
    for (int i = 0; i < 2200; i++) begin
      @(negedge clk);
      if (sample_done_o) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ctl", ctl_q_o, 0);
    chk("R1", "sysmode", sysmode_o, 0);
    chk("R1", "busy", rst_busy_o, 0);
    chk("R1", "start", conv_start_o, 0);
    chk("R1", "done", sample_done_o, 0);
  endtask

  task automatic t_layout_standby();
    int starts = 0;
    wr_ctl(8'hA4);
    chk("R2", "readback", ctl_q_o, 8'hA4);
    wr_ctl(8'hFC);
    chk("R2", "readback2", ctl_q_o, 8'hFC);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (conv_start_o) starts++;
    end
    chk("R6", "starts in standby", starts, 0);
    wr_ctl(8'h00);
  endtask

  task automatic t_rate(input int r, input int o, input string req);
    int seen, len, exp;
    stop_all();
    wr_ctl(8'((r << 5) | (o << 3) | 1));
    wait_start(seen);
    chk(req, "start seen", seen, 1);
    measure(len, 0, 8'h00);
    exp = (1 << ((r > 4) ? 4 : r)) * (16 << o);
    chk(req, "window len", len, exp);
    @(negedge clk);
    chk("R5", "restart next cycle", conv_start_o, 1);
  endtask

  task automatic t_mid_change();
    int seen, len;
    stop_all();
    wr_ctl(8'h01);
    wait_start(seen);
    measure(len, 5, 8'h09);
    chk("R9", "current window", len, 16);
    @(negedge clk);
    chk("R9", "next start", conv_start_o, 1);
    measure(len, 0, 8'h00);
    chk("R9", "next window", len, 32);
  endtask

  task automatic t_trigger();
    int seen, len, starts = 0;
    stop_all();
    wr_ctl(8'h02);
    wait_start(seen);
    chk("R7", "one-shot start", seen, 1);
    chk("R7", "trigger held", ctl_q_o, 8'h02);
    measure(len, 0, 8'h00);
    chk("R7", "one-shot len", len, 16);
    chk("R7", "trigger cleared", ctl_q_o, 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (conv_start_o) starts++;
    end
    chk("R7", "no repeat", starts, 0);
  endtask

  task automatic t_trig_active();
    stop_all();
    wr_ctl(8'h03);
    chk("R8", "trigger dropped", ctl_q_o, 8'h01);
  endtask

  task automatic t_sysmode();
    stop_all();
    raw_i = 1'b1;
    wr_ctl(8'h01);
    @(negedge clk);
    chk("R10", "active raw", sysmode_o, 1);
    raw_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "active corrected", sysmode_o, 2);
    stop_all();
    chk("R10", "standby", sysmode_o, 0);
  endtask

  task automatic t_reset_req();
    int cnt;
    @(negedge clk); rst_req_i = 1'b1;
    @(negedge clk); rst_req_i = 1'b0;
    chk("R11", "busy rises", rst_busy_o, 1);
    cnt = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rst_busy_o) break;
      cnt++;
    end
    chk("R11", "busy length", cnt, RST_T);
    @(negedge clk); rst_req_i = 1'b1;
    @(negedge clk); rst_req_i = 1'b0; tick_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R13", "busy holds without tick", rst_busy_o, 1);
    tick_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cnt++;
      if (!rst_busy_o) break;
    end
    chk("R13", "busy resumes", cnt, RST_T);
  endtask

  task automatic t_auto();
    int cnt, len;
    stop_all();
    auto_rst_en_i = 1'b1;
    wr_ctl(8'h01);
    @(negedge clk);
    chk("R12", "busy before window", rst_busy_o, 1);
    cnt = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rst_busy_o) break;
      cnt++;
    end
    chk("R12", "auto busy length", cnt, RST_T);
    chk("R12", "start on busy fall", conv_start_o, 1);
    measure(len, 0, 8'h00);
    chk("R12", "window after reset", len, 16);
    auto_rst_en_i = 1'b0;
  endtask

  task automatic t_no_tick();
    int seen, cnt, dones = 0;
    stop_all();
    wr_ctl(8'h01);
    wait_start(seen);
    repeat (3) @(negedge clk);
    tick_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (sample_done_o) dones++;
    end
    chk("R13", "no done while paused", dones, 0);
    tick_i = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      cnt++;
      if (sample_done_o) break;
    end
    chk("R13", "remaining ticks", cnt, 13);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout_standby();
    t_rate(0, 0, "R3");
    t_rate(2, 1, "R3");
    t_rate(3, 2, "R3");
    t_rate(1, 3, "R3");
    t_rate(4, 0, "R4");
    t_rate(6, 0, "R4");
    t_rate(7, 1, "R4");
    t_mid_change();
    t_trigger();
    t_trig_active();
    t_sysmode();
    stop_all();
    t_reset_req();
    t_auto();
    t_no_tick();
    stop_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule